// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block lets software read and burn a one-time-programmable bit array over a small register bus. The array is modelled by a synthesizable register store in which each cell needs a fixed number of program pulses, derived from its location, before it reads as 1. A read cycle copies one addressed byte into the data register. A program cycle burns one addressed bit, using a loop of timed pulses that stops as soon as the bit verifies as set.

Programming is guarded by an unlock pair of writes to the control register. It can be shut off for good by a sticky disable bit. Completion of any cycle raises a pending flag, which drives an interrupt when that interrupt is enabled. While a cycle runs, the register bank refuses changes. The one exception is clearing the pending flag.

The bus accepts every request in the cycle it is presented and returns read data combinationally in that same cycle. `bus_addr` selects a 32-bit register by word index: 0 status, 1 address, 2 data, 3 configuration, 4 key index, 5 control.

Top module: `otp_ctrl`

## Requirements
- R1: After reset the status register reads 0x1 (ready set, all other bits clear), and the address, data, configuration, key-index and control registers read 0.
- R2: A program cycle starts only when the control register is written with 0x00000001 and the next accepted write is 0xBF79E5D0 to the control register. Any other accepted write in between cancels the arming, and the later unlock word then starts nothing.
- R3: Writing 0x02 to the control register starts a read cycle. Ready (status bit 0) is low for READ_LAT cycles. The addressed byte then appears in data bits [7:0], and status bit 1 (read done) is set. Bit 1 clears when the next cycle starts.
- R4: The status bit layout is: bit 0 ready, bit 1 read done, bit 2 interrupt enable (read/write), bit 3 program error, bit 4 completion pending. All other bits read 0.
- R5: The address register holds the bit position in [2:0] and the byte address in [15:2+1]. Bit 16 reads 1 while a program cycle is running and 0 otherwise.
- R6: The program loop works in pulses of PULSE_CYC cycles, and each pulse is followed by one verify cycle. A cell with byte index A and bit position B needs H = ((5·A + 3·B) mod 23) + 1 pulses. The loop stops at the first pulse count of at least MIN_PULSES (4) at which the bit reads 1. An already-set bit therefore takes exactly 4 pulses. Ready stays low for pulses·(PULSE_CYC+1) cycles.
- R7: If the bit still reads 0 after MAX_PULSES (20) pulses, the cycle ends with status bit 3 set and ready high again, and the bit stays 0. Bit 3 clears when the next cycle starts.
- R8: Configuration bit 31 is sticky: writing it 1 sets it, and only reset clears it. While it is set, the unlock pair starts no program cycle, but read cycles still work.
- R9: Writing 0x01 to the data register clears it to 0. Writing any other value to it has no effect.
- R10: The key-index register stores only bit 0 (key valid), bits [6:4] (key size, 4/5/6 for 128/192/256 bits) and bits [19:18] (key index). All other bits read 0.
- R11: Writes accepted while ready is low change no register. The exception is status bit 4: writing it with 1 clears the pending flag at any time.
- R12: Pending (status bit 4) is set when any read or program cycle ends. `irq` equals pending AND interrupt enable.
- R13: The array has 2^AW bytes, indexed by the low AW bits of the byte address, so higher address bits alias. A programmed 1 never returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_vld | input | 1 | Register request valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdy | output | 1 | Request accepted (same cycle) |
| bus_rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Completion interrupt |

## Verification
The pulse loop is driven with cells whose required pulse count lies below the minimum, in the middle of the range, exactly at the maximum, and above it. These cases separate the minimum-pulse floor, early stopping, success on the last allowed pulse, and failure with the error flag. The busy time read through the status register shows how many pulses were issued. Random programs over a small byte window hit bits that are already set and mix successes with failures. Every byte is then read back against a bench model of the array.

The unlock is tried three ways: as a clean pair, broken by an intervening write, and blocked by the disable bit. Writes made while a cycle runs show that registers are frozen except for the pending-clear.

// File: rtl/otp_pkg.sv
package otp_pkg;

  // register word indices on the bus
  localparam logic [2:0] RG_STAT = 3'd0;
  localparam logic [2:0] RG_ADDR = 3'd1;
  localparam logic [2:0] RG_DATA = 3'd2;
  localparam logic [2:0] RG_CFG  = 3'd3;
  localparam logic [2:0] RG_KEY  = 3'd4;
  localparam logic [2:0] RG_CTRL = 3'd5;

  // command and magic words
  localparam logic [31:0] ARM_WORD      = 32'h0000_0001;
  localparam logic [31:0] UNLOCK_WORD   = 32'hBF79_E5D0;
  localparam logic [31:0] READ_WORD     = 32'h0000_0002;
  localparam logic [31:0] DATA_CLR_WORD = 32'h0000_0001;
  localparam logic [31:0] KEY_MASK      = 32'h000C_0071;

  // byte address field width in the address register
  localparam int unsigned BYTE_FIELD_W = 13;
  // pulse counter width (max pulse count must stay below 2**PCNT_W)
  localparam int unsigned PCNT_W = 6;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_READ  = 2'd1,
    SQ_PULSE = 2'd2,
    SQ_CHECK = 2'd3
  } seq_st_e;

  // pulses a cell needs before it reads as 1
  function automatic logic [4:0] fuse_hardness(input logic [BYTE_FIELD_W-1:0] byte_a,
                                               input logic [2:0] bitp);
    logic [16:0] sum;
    logic [16:0] rem;
    sum = 17'(byte_a) * 17'd5 + 17'(bitp) * 17'd3;
    rem = sum % 17'd23;
    return rem[4:0] + 5'd1;
  endfunction

  // status word assembly
  function automatic logic [31:0] pack_status(input logic ready, input logic rd_done,
                                              input logic ien, input logic perr,
                                              input logic pend);
    return {27'd0, pend, perr, ien, rd_done, ready};
  endfunction

endpackage

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
  import otp_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pulse_fire,
  input  logic [PCNT_W-1:0] pulse_num,
  input  logic [AW-1:0]     cell_byte,
  input  logic [2:0]        cell_bit,
  output logic [7:0]        byte_data,
  output logic              cell_val
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DEPTH-1:0][7:0] mem_q;
  logic [4:0]            hard;
  logic                  burn_now;

  assign hard      = fuse_hardness(BYTE_FIELD_W'(cell_byte), cell_bit);
  assign burn_now  = pulse_fire && (pulse_num >= PCNT_W'(hard));
  assign byte_data = mem_q[cell_byte];
  assign cell_val  = mem_q[cell_byte][cell_bit];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (burn_now) begin
      mem_q[cell_byte][cell_bit] <= 1'b1;
    end
  end

  // R13: a burned cell never reverts
  a_r13_never_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(mem_q) & ~mem_q) == '0));

endmodule

// File: rtl/otp_unlock.sv
module otp_unlock
  import otp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_eff,
  input  logic        wr_ctrl,
  input  logic [31:0] wdata,
  output logic        go
);

  logic armed_q;

  assign go = armed_q && wr_eff && wr_ctrl && (wdata == UNLOCK_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (wr_eff) begin
      armed_q <= wr_ctrl && (wdata == ARM_WORD);
    end
  end

  // R2: arming appears only after an accepted write
  a_r2_arm_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(wr_eff));
  // R2: an unlock consumes the arming
  a_r2_unlock_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !armed_q);

endmodule

// File: rtl/otp_seq.sv
module otp_seq
  import otp_pkg::*;
#(
  parameter int unsigned READ_LAT   = 2,
  parameter int unsigned PULSE_CYC  = 4,
  parameter int unsigned MIN_PULSES = 4,
  parameter int unsigned MAX_PULSES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_rd,
  input  logic              start_pg,
  input  logic              cell_val,
  output logic              idle,
  output logic              pg_busy,
  output logic              pulse_fire,
  output logic [PCNT_W-1:0] pulse_num,
  output logic              rd_done,
  output logic              pg_done,
  output logic              pg_fail
);

  localparam int unsigned LONGEST = (READ_LAT > PULSE_CYC) ? READ_LAT : PULSE_CYC;
  localparam int unsigned CW      = $clog2(LONGEST + 1);

  seq_st_e           st_q;
  logic [CW-1:0]     cnt_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic              at_zero;
  logic              verified;
  logic              exhausted;

  assign at_zero    = (cnt_q == '0);
  assign idle       = (st_q == SQ_IDLE);
  assign pg_busy    = (st_q == SQ_PULSE) || (st_q == SQ_CHECK);
  assign pulse_fire = (st_q == SQ_PULSE) && at_zero;
  assign pulse_num  = pcnt_q + PCNT_W'(1);
  assign rd_done    = (st_q == SQ_READ) && at_zero;
  assign verified   = (pcnt_q >= PCNT_W'(MIN_PULSES)) && cell_val;
  assign exhausted  = (pcnt_q >= PCNT_W'(MAX_PULSES));
  assign pg_done    = (st_q == SQ_CHECK) && (verified || exhausted);
  assign pg_fail    = (st_q == SQ_CHECK) && exhausted && !cell_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      pcnt_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (start_rd) begin
            st_q  <= SQ_READ;
            cnt_q <= CW'(READ_LAT - 1);
          end else if (start_pg) begin
            st_q   <= SQ_PULSE;
            cnt_q  <= CW'(PULSE_CYC - 1);
            pcnt_q <= '0;
          end
        end
        SQ_READ: begin
          if (at_zero) st_q <= SQ_IDLE;
          else         cnt_q <= cnt_q - CW'(1);
        end
        SQ_PULSE: begin
          if (at_zero) begin
            pcnt_q <= pulse_num;
            st_q   <= SQ_CHECK;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        SQ_CHECK: begin
          if (pg_done) begin
            st_q <= SQ_IDLE;
          end else begin
            st_q  <= SQ_PULSE;
            cnt_q <= CW'(PULSE_CYC - 1);
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // R6: below the minimum pulse count the loop always pulses again
  a_r6_min_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_CHECK) && (pcnt_q < PCNT_W'(MIN_PULSES)) |=> (st_q == SQ_PULSE));
  // R7: the pulse count never passes the maximum
  a_r7_pulse_cap: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_fire |-> (pulse_num <= PCNT_W'(MAX_PULSES)));
  // R3: a read request enters the read wait
  a_r3_read_enter: assert property (@(posedge clk) disable iff (!rst_n)
    idle && start_rd |=> (st_q == SQ_READ));

endmodule

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned READ_LAT   = 2,
  parameter int unsigned PULSE_CYC  = 4,
  parameter int unsigned MIN_PULSES = 4,
  parameter int unsigned MAX_PULSES = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_vld,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic        bus_rdy,
  output logic [31:0] bus_rdata,
  output logic        irq
);

  localparam int unsigned ADDR_REG_W = 3 + BYTE_FIELD_W;

  logic [ADDR_REG_W-1:0] addr_q;
  logic [7:0]            data_q;
  logic                  dis_q;
  logic [31:0]           key_q;
  logic                  ien_q;
  logic                  rdst_q;
  logic                  perr_q;
  logic                  pend_q;

  logic              wr_acc;
  logic              wr_eff;
  logic              ready;
  logic              go;
  logic              rd_start;
  logic              pg_start;
  logic              any_start;
  logic              pg_busy;
  logic              pulse_fire;
  logic [PCNT_W-1:0] pulse_num;
  logic              rd_done;
  logic              pg_done;
  logic              pg_fail;
  logic [7:0]        byte_data;
  logic              cell_val;

  assign bus_rdy   = bus_vld;
  assign wr_acc    = bus_vld && bus_we;
  assign wr_eff    = wr_acc && ready;
  assign rd_start  = wr_eff && (bus_addr == RG_CTRL) && (bus_wdata == READ_WORD);
  assign pg_start  = go && !dis_q;
  assign any_start = rd_start || pg_start;
  assign irq       = pend_q && ien_q;

  otp_unlock u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_eff  (wr_eff),
    .wr_ctrl (bus_addr == RG_CTRL),
    .wdata   (bus_wdata),
    .go      (go)
  );

  otp_seq #(
    .READ_LAT   (READ_LAT),
    .PULSE_CYC  (PULSE_CYC),
    .MIN_PULSES (MIN_PULSES),
    .MAX_PULSES (MAX_PULSES)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_rd   (rd_start),
    .start_pg   (pg_start),
    .cell_val   (cell_val),
    .idle       (ready),
    .pg_busy    (pg_busy),
    .pulse_fire (pulse_fire),
    .pulse_num  (pulse_num),
    .rd_done    (rd_done),
    .pg_done    (pg_done),
    .pg_fail    (pg_fail)
  );

  otp_fuse_array #(.AW(AW)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .pulse_fire (pulse_fire),
    .pulse_num  (pulse_num),
    .cell_byte  (addr_q[3 +: AW]),
    .cell_bit   (addr_q[2:0]),
    .byte_data  (byte_data),
    .cell_val   (cell_val)
  );

  // register bank
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      dis_q  <= 1'b0;
      key_q  <= '0;
      ien_q  <= 1'b0;
      rdst_q <= 1'b0;
      perr_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_eff) begin
        unique case (bus_addr)
          RG_STAT: ien_q <= bus_wdata[2];
          RG_ADDR: addr_q <= bus_wdata[ADDR_REG_W-1:0];
          RG_DATA: if (bus_wdata == DATA_CLR_WORD) data_q <= '0;
          RG_CFG:  if (bus_wdata[31]) dis_q <= 1'b1;
          RG_KEY:  key_q <= bus_wdata & KEY_MASK;
          default: ;
        endcase
      end
      if (any_start) begin
        rdst_q <= 1'b0;
        perr_q <= 1'b0;
      end
      if (rd_done) begin
        rdst_q <= 1'b1;
        data_q <= byte_data;
      end
      if (pg_fail) perr_q <= 1'b1;
      if (rd_done || pg_done)                                   pend_q <= 1'b1;
      else if (wr_acc && (bus_addr == RG_STAT) && bus_wdata[4]) pend_q <= 1'b0;
    end
  end

  // read mux
  always_comb begin
    unique case (bus_addr)
      RG_STAT: bus_rdata = pack_status(ready, rdst_q, ien_q, perr_q, pend_q);
      RG_ADDR: bus_rdata = {15'd0, pg_busy, addr_q};
      RG_DATA: bus_rdata = {24'd0, data_q};
      RG_CFG:  bus_rdata = {dis_q, 31'd0};
      RG_KEY:  bus_rdata = key_q;
      default: bus_rdata = '0;
    endcase
  end

  // R11: a busy write leaves the address register alone
  a_r11_busy_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && !ready && (bus_addr == RG_ADDR) |=> $stable(addr_q));
  // R8: no program cycle may begin while disabled
  a_r8_disabled_no_prog: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q && !pg_busy |=> !pg_busy);
  // R12: every cycle end leaves the pending flag set
  a_r12_end_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done || pg_done) |=> pend_q);
  // R2: an accepted unlock drops ready on the next cycle
  a_r2_start_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pg_start |=> !ready && pg_busy);

endmodule

// File: tb/otp_ctrl_bench.sv
module otp_ctrl_bench;

  localparam int AWB = 8, RLB = 2, PCB = 4, MINB = 4, MAXB = 20;
  localparam int I_ST = 0, I_AD = 1, I_DT = 2, I_CF = 3, I_KY = 4, I_CT = 5;
  localparam logic [31:0] MAGIC = 32'hBF79E5D0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_vld = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rdy;
  logic [31:0] bus_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;
  logic [7:0] mdl [256];

  always #2 clk = ~clk;

  otp_ctrl #(.AW(AWB), .READ_LAT(RLB), .PULSE_CYC(PCB), .MIN_PULSES(MINB), .MAX_PULSES(MAXB))
    u_otp_ctrl (.clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_we(bus_we),
                .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdy(bus_rdy),
                .bus_rdata(bus_rdata), .irq(irq));

  function automatic int cell_need(int b, int k);
    int s = b * 5 + k * 3;
    while (s >= 23) s = s - 23;
    return s + 1;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(int a, logic [31:0] d);
    bus_vld = 1'b1; bus_we = 1'b1; bus_addr = a[2:0]; bus_wdata = d;
    @(posedge clk); #1;
    bus_vld = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(int a, output logic [31:0] d);
    bus_vld = 1'b1; bus_we = 1'b0; bus_addr = a[2:0];
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_vld = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] s;
    n = 0;
    forever begin
      bus_rd(I_ST, s);
      if (s[0]) break;
      n++;
      if (n > 2000) break;
    end
  endtask

  task automatic read_byte(int b, output logic [7:0] v);
    logic [31:0] d;
    int n;
    bus_wr(I_AD, b << 3);
    bus_wr(I_CT, 32'h2);
    wait_idle(n);
    chk("R3 read busy length", n, RLB);
    bus_rd(I_DT, d);
    v = d[7:0];
  endtask

  task automatic prog_cell(int b, int k);
    logic [31:0] a, s;
    int n, need, pulses, ix;
    bit already, fail;
    ix = b % 256;
    need = cell_need(ix, k);
    already = mdl[ix][k];
    if (already || need <= MINB) pulses = MINB;
    else if (need <= MAXB) pulses = need;
    else pulses = MAXB;
    fail = !already && need > MAXB;
    bus_wr(I_AD, (b << 3) | k);
    bus_wr(I_CT, 32'h1);
    bus_wr(I_CT, MAGIC);
    bus_rd(I_AD, a);
    chk("R5 program-active flag", a[16], 1);
    wait_idle(n);
    chk("R6 program busy cycles", n + 1, pulses * (PCB + 1));
    bus_rd(I_ST, s);
    chk("R7 error flag", s[3], fail);
    if (!fail) mdl[ix][k] = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0] v;
    int n;
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < 256; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset values
    bus_rd(I_ST, d); chk("R1 status reset", d, 32'h1);
    bus_rd(I_AD, d); chk("R1 address reset", d, 0);
    bus_rd(I_DT, d); chk("R1 data reset", d, 0);
    bus_rd(I_CF, d); chk("R1 config reset", d, 0);
    bus_rd(I_KY, d); chk("R1 key reset", d, 0);
    bus_rd(I_CT, d); chk("R1 control reset", d, 0);

    // R10 key-index masking
    bus_wr(I_KY, 32'hFFFF_FFFF); bus_rd(I_KY, d); chk("R10 key mask", d, 32'h000C_0071);
    bus_wr(I_KY, 32'h0008_0051); bus_rd(I_KY, d); chk("R10 key store", d, 32'h0008_0051);

    // R6 below minimum, middle, exactly max; R7 over max
    prog_cell(0, 0);
    prog_cell(0, 3);
    prog_cell(2, 3);
    prog_cell(4, 0);
    read_byte(4, v); chk("R7 failed bit stays 0", v, 8'h00);
    read_byte(0, v); chk("R3 read byte 0", v, 8'h09);
    bus_rd(I_ST, d); chk("R4 read-done bit", d[1], 1);
    chk("R4 error cleared by new cycle", d[3], 0);
    read_byte(2, v); chk("R3 read byte 2", v, 8'h08);
    prog_cell(0, 0);  // already set: minimum pulses

    // R9 data clear
    bus_wr(I_DT, 32'h5); bus_rd(I_DT, d); chk("R9 other value ignored", d, 32'h8);
    bus_wr(I_DT, 32'h1); bus_rd(I_DT, d); chk("R9 clear", d, 0);

    // R2 broken arming
    bus_wr(I_AD, (5 << 3) | 1);
    bus_wr(I_CT, 32'h1);
    bus_wr(I_DT, 32'h5);
    bus_wr(I_CT, MAGIC);
    bus_rd(I_ST, d); chk("R2 broken unlock leaves ready", d[0], 1);
    read_byte(5, v); chk("R2 broken unlock no burn", v, 8'h00);

    // R11 busy writes frozen, pending clear allowed
    bus_wr(I_AD, (6 << 3) | 2);
    bus_wr(I_CT, 32'h1);
    bus_wr(I_CT, MAGIC);
    bus_wr(I_AD, 32'h0000_7777);
    bus_wr(I_ST, 32'h0000_0014);
    bus_rd(I_ST, d); chk("R11 pending cleared while busy", d[4], 0);
    chk("R11 enable not written while busy", d[2], 0);
    wait_idle(n);
    bus_rd(I_AD, d); chk("R11 address frozen", d, (6 << 3) | 2);
    mdl[6][2] = (cell_need(6, 2) <= MAXB);

    // R12 interrupt
    chk("R12 irq low with enable off", irq, 0);
    bus_wr(I_ST, 32'h4);
    #1 chk("R12 irq follows pending", irq, 1);
    bus_wr(I_ST, 32'h14);
    #1 chk("R12 irq cleared", irq, 0);
    read_byte(1, v);
    #1 chk("R12 irq after read end", irq, 1);

    // random programs
    for (int i = 0; i < 24; i++) begin
      prog_cell($urandom_range(15, 0), $urandom_range(7, 0));
    end
    for (int b = 0; b < 16; b++) begin
      read_byte(b, v);
      chk("R13 byte matches model", v, mdl[b]);
    end
    read_byte(256 + 3, v); chk("R13 alias of byte 3", v, mdl[3]);

    // R8 sticky disable
    bus_wr(I_CF, 32'h8000_0000); bus_rd(I_CF, d); chk("R8 disable set", d, 32'h8000_0000);
    bus_wr(I_CF, 32'h0); bus_rd(I_CF, d); chk("R8 disable sticky", d, 32'h8000_0000);
    bus_wr(I_AD, (7 << 3) | 0);
    bus_wr(I_CT, 32'h1);
    bus_wr(I_CT, MAGIC);
    bus_rd(I_AD, d); chk("R8 no program while disabled", d[16], 0);
    bus_rd(I_ST, d); chk("R8 ready stays high", d[0], 1);
    read_byte(7, v); chk("R8 reads still work", v, mdl[7]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule